// File: doc/BRIEF.md
# Three-Wire Serial Character Display Controller

This block drives a character display with a parallel data bus, using only three signal wires on the data path. Each byte is presented serially on a data line and clocked into an external serial-in, parallel-out register whose outputs feed the display's data pins. After the bits are in place, the block pulses the display enable line so the display latches them. Register select is a direct output and is not on the shift chain, so the host can still choose the display's bus width.

A host supplies a byte, a register-select flag and a bus-mode flag on a valid/ready handshake. In 8-bit mode one shift group of eight bits and one enable strobe make up a transfer. In 4-bit mode the byte is split into two nibbles, and each nibble gets its own four-bit shift group and strobe. The enable high time, the settle gap after each strobe and the shift-clock half period are parameters counted in system clock cycles. Their defaults give at least 1 µs high and 40 µs settle at 125 MHz.

Top module: `lcd_serial_ctrl`

## Requirements
- R1: After reset, `in_ready` is 1, `ser_clk` is 1, and `ser_data`, `lcd_en` and `lcd_rs` are 0.
- R2: A transfer is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the cycle after acceptance until the last settle gap of that transfer has ended.
- R3: With `in_bus4` = 0 at acceptance, exactly eight rising edges of `ser_clk` come before the single enable strobe. Bits go most significant first, so at the strobe an 8-bit register that shifts on each rising edge holds the accepted byte, with bit 7 in its highest position.
- R4: With `in_bus4` = 1 at acceptance, there are two strobes, and each is preceded by exactly four rising edges of `ser_clk`. The first group carries bits 7..4 and the second carries bits 3..0, each most significant first. At each strobe the four most recently shifted positions hold that nibble.
- R5: `ser_data` never changes in the cycle in which `ser_clk` rises.
- R6: `lcd_en` stays high for exactly EN_HIGH_CYC clock cycles per strobe, and it is high only while `ser_clk` is high.
- R7: After each falling edge of `lcd_en`, at least SETTLE_CYC cycles pass before `ser_clk` falls again or `in_ready` returns to 1.
- R8: `lcd_rs` takes the value of `in_rs` on the acceptance edge and changes at no other time.
- R9: `in_data`, `in_rs`, `in_bus4` and `in_valid` have no effect while `in_ready` is 0.
- R10: Whenever `in_ready` is 1, `ser_clk` is 1, `ser_data` is 0 and `lcd_en` is 0.
- R11: If `in_valid` is held high when a transfer completes, the next transfer is accepted on the first edge where `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Host offers a byte |
| in_ready | output | 1 | Controller can accept a byte |
| in_data | input | 8 | Byte to send to the display |
| in_rs | input | 1 | Register-select value for this byte |
| in_bus4 | input | 1 | 1 = 4-bit display bus (two nibbles), 0 = 8-bit |
| ser_data | output | 1 | Serial data to the external shift register |
| ser_clk | output | 1 | Shift clock; the register captures on its rising edge |
| lcd_en | output | 1 | Display enable strobe |
| lcd_rs | output | 1 | Display register select |

## Verification
Two events can fall in the same cycle: a transfer finishing (ready returning high) and a new acceptance, because the host holds valid high across the end of the settle gap. The bench provokes this with back-to-back sends in both bus modes. It judges the result by requiring ready to be low again on the very next sample, register select to have switched to the new value, and the following strobes to carry the new byte. While a transfer is busy, the bench scrambles data, select and mode on every cycle, so a controller that sampled its inputs late would show the wrong contents at the strobe.

// File: rtl/lcd_ser_pkg.sv
// Shared types and widths for the three-wire display controller.
// Assumes: a display byte is always eight bits; a nibble is four.
package lcd_ser_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_STROBE = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/lcd_bit_shifter.sv
// Serialises up to DW bits, most significant first, onto sdata/sclk.
// For each bit, sclk is low for HALF_CYC cycles with the data already set,
// then high for HALF_CYC cycles. The external register samples on the rise.
// Assumes: start arrives only while the shifter is idle; nbits is 1..DW.
module lcd_bit_shifter #(
    parameter int HALF_CYC = 4,
    parameter int DW       = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [DW-1:0]               bits,
    input  logic [$clog2(DW+1)-1:0]     nbits,
    output logic                        sclk,
    output logic                        sdata,
    output logic                        done
);
    localparam int CW = $clog2(DW + 1);
    localparam int PW = $clog2(HALF_CYC + 1);

    logic [DW-1:0] shreg;
    logic [CW-1:0] bits_left;
    logic [PW-1:0] phase_cnt;
    logic          active;
    logic          low_phase;

    // Bit sequencer: load on start, then alternate low and high phases per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            bits_left <= '0;
            phase_cnt <= '0;
            active    <= 1'b0;
            low_phase <= 1'b0;
            sclk      <= 1'b1;
            sdata     <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                shreg     <= bits;
                bits_left <= nbits;
                phase_cnt <= '0;
                active    <= 1'b1;
                low_phase <= 1'b1;
                sclk      <= 1'b0;
                sdata     <= bits[DW-1];
            end else if (active) begin
                if (phase_cnt == PW'(HALF_CYC - 1)) begin
                    phase_cnt <= '0;
                    if (low_phase) begin
                        sclk      <= 1'b1;
                        low_phase <= 1'b0;
                    end else if (bits_left == CW'(1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                        sdata  <= 1'b0;
                    end else begin
                        shreg     <= {shreg[DW-2:0], 1'b0};
                        sdata     <= shreg[DW-2];
                        sclk      <= 1'b0;
                        low_phase <= 1'b1;
                        bits_left <= bits_left - CW'(1);
                    end
                end else begin
                    phase_cnt <= phase_cnt + PW'(1);
                end
            end
        end
    end

    // R5: data must be settled across the sampling edge
    a_r5_data_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(sdata));

    // R10: once the group is finished the line rests low with the clock high
    a_r10_rest_levels: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sclk && !sdata));
endmodule

// File: rtl/lcd_strobe_gen.sv
// Drives the enable pulse for EN_CYC cycles, then holds it low for SETTLE_CYC
// cycles, then pulses done for one cycle.
// Assumes: start only while idle; EN_CYC >= 1 and SETTLE_CYC >= 1.
module lcd_strobe_gen #(
    parameter int EN_CYC     = 125,
    parameter int SETTLE_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic en,
    output logic done
);
    localparam int MAXC = (EN_CYC > SETTLE_CYC) ? EN_CYC : SETTLE_CYC;
    localparam int TW   = $clog2(MAXC + 1);

    logic [TW-1:0] cnt;
    logic          active;
    logic          in_settle;

    // Pulse-then-settle timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            active    <= 1'b0;
            in_settle <= 1'b0;
            en        <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                en        <= 1'b1;
                active    <= 1'b1;
                in_settle <= 1'b0;
                cnt       <= '0;
            end else if (active) begin
                if (!in_settle) begin
                    if (cnt == TW'(EN_CYC - 1)) begin
                        en        <= 1'b0;
                        in_settle <= 1'b1;
                        cnt       <= '0;
                    end else begin
                        cnt <= cnt + TW'(1);
                    end
                end else begin
                    if (cnt == TW'(SETTLE_CYC - 1)) begin
                        active    <= 1'b0;
                        in_settle <= 1'b0;
                        done      <= 1'b1;
                        cnt       <= '0;
                    end else begin
                        cnt <= cnt + TW'(1);
                    end
                end
            end
        end
    end

    // R7: completion can never come straight out of the enable pulse
    a_r7_no_done_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |-> !done);

    // R6: the pulse only begins on a start request
    a_r6_en_starts_on_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> $past(start));
endmodule

// File: rtl/lcd_serial_ctrl.sv
// Top of the three-wire display controller. It accepts a byte on valid/ready,
// shifts it (or each nibble in 4-bit mode, upper first) to an external
// shift register, and strobes the display enable after each group.
// Assumes: the external register shifts toward its high output on ser_clk rise.
module lcd_serial_ctrl
    import lcd_ser_pkg::*;
#(
    parameter int HALF_CYC    = 63,
    parameter int EN_HIGH_CYC = 125,
    parameter int SETTLE_CYC  = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_rs,
    input  logic              in_bus4,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              lcd_en,
    output logic              lcd_rs
);
    localparam int CW = $clog2(BYTE_W + 1);

    ctl_state_e        state;
    logic [BYTE_W-1:0] data_q;
    logic              bus4_q;
    logic              lo_pass;
    logic              sh_start;
    logic              st_start;
    logic              sh_done;
    logic              st_done;
    logic              accept;
    logic [BYTE_W-1:0] sh_bits;
    logic [CW-1:0]     sh_nbits;

    assign in_ready = (state == ST_IDLE);
    assign accept   = in_valid && in_ready;

    // Pick the group to shift: the whole byte, or one nibble left-aligned.
    always_comb begin
        if (bus4_q) begin
            sh_bits  = lo_pass ? {data_q[NIB_W-1:0], {(BYTE_W-NIB_W){1'b0}}}
                               : {data_q[BYTE_W-1:NIB_W], {(BYTE_W-NIB_W){1'b0}}};
            sh_nbits = CW'(NIB_W);
        end else begin
            sh_bits  = data_q;
            sh_nbits = CW'(BYTE_W);
        end
    end

    // Transfer sequencer: accept, shift, strobe, and repeat once for the low nibble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            data_q   <= '0;
            bus4_q   <= 1'b0;
            lo_pass  <= 1'b0;
            sh_start <= 1'b0;
            st_start <= 1'b0;
            lcd_rs   <= 1'b0;
        end else begin
            sh_start <= 1'b0;
            st_start <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        data_q   <= in_data;
                        bus4_q   <= in_bus4;
                        lcd_rs   <= in_rs;
                        lo_pass  <= 1'b0;
                        sh_start <= 1'b1;
                        state    <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (sh_done) begin
                        st_start <= 1'b1;
                        state    <= ST_STROBE;
                    end
                end
                ST_STROBE: begin
                    if (st_done) begin
                        if (bus4_q && !lo_pass) begin
                            lo_pass  <= 1'b1;
                            sh_start <= 1'b1;
                            state    <= ST_SHIFT;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    lcd_bit_shifter #(
        .HALF_CYC (HALF_CYC),
        .DW       (BYTE_W)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sh_start),
        .bits  (sh_bits),
        .nbits (sh_nbits),
        .sclk  (ser_clk),
        .sdata (ser_data),
        .done  (sh_done)
    );

    lcd_strobe_gen #(
        .EN_CYC     (EN_HIGH_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .start (st_start),
        .en    (lcd_en),
        .done  (st_done)
    );

    // R10: idle outputs whenever the host may hand over a byte
    a_r10_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (ser_clk && !ser_data && !lcd_en));

    // R6: the strobe never overlaps a low shift-clock phase
    a_r6_en_with_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_en |-> ser_clk);

    // R8: register select moves only on acceptance
    a_r8_rs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(accept) |-> $stable(lcd_rs));

    // R2: busy immediately after acceptance
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready);
endmodule

// File: tb/sim_lcd_serial_ctrl.sv
module sim_lcd_serial_ctrl;
    localparam int HALF = 2;
    localparam int ENC  = 4;
    localparam int SETL = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       in_rs = 1'b0;
    logic       in_bus4 = 1'b0;
    logic       ser_data, ser_clk, lcd_en, lcd_rs;

    always #4 clk = ~clk;

    lcd_serial_ctrl #(.HALF_CYC(HALF), .EN_HIGH_CYC(ENC), .SETTLE_CYC(SETL)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_rs(in_rs), .in_bus4(in_bus4),
        .ser_data(ser_data), .ser_clk(ser_clk), .lcd_en(lcd_en), .lcd_rs(lcd_rs));

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [7:0] exp_val [128];
    logic       exp_rs  [128];
    int         exp_n   [128];
    int wr_ptr = 0;
    int rd_ptr = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void push(input logic rs, input logic [7:0] v, input int n);
        exp_rs[wr_ptr]  = rs;
        exp_val[wr_ptr] = v;
        exp_n[wr_ptr]   = n;
        wr_ptr++;
    endfunction

    // External register model and timing monitor, sampled away from the clock edge.
    logic [7:0] sr = '0;
    int  rises = 0, en_hi = 0, gap = 0;
    bit  counting = 1'b0;
    logic en_p = 1'b0, clk_p = 1'b1, rdy_p = 1'b1, dat_p = 1'b0;
    int  idle_bad = 0, r5_bad = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (ser_clk && !clk_p) begin
                if (ser_data !== dat_p) r5_bad++;
                sr = {sr[6:0], ser_data};
                rises++;
            end
            if (counting && ((in_ready && !rdy_p) || (!ser_clk && clk_p))) begin
                chk(gap >= SETL, "R7", gap, SETL);
                counting = 1'b0;
            end
            if (counting && !lcd_en) gap++;
            if (lcd_en && !en_p) begin
                if (rd_ptr < wr_ptr) begin
                    if (exp_n[rd_ptr] == 4) begin
                        chk(sr[3:0] == exp_val[rd_ptr][3:0], "R4,R9", sr[3:0], exp_val[rd_ptr][3:0]);
                        chk(rises == 4, "R4", rises, 4);
                    end else begin
                        chk(sr == exp_val[rd_ptr], "R3,R9", sr, exp_val[rd_ptr]);
                        chk(rises == 8, "R3", rises, 8);
                    end
                    chk(lcd_rs == exp_rs[rd_ptr], "R8", lcd_rs, exp_rs[rd_ptr]);
                end else begin
                    chk(1'b0, "R2 unexpected strobe", rd_ptr, wr_ptr);
                end
                rd_ptr++;
                rises = 0;
                en_hi = 0;
            end
            if (lcd_en) en_hi++;
            if (!lcd_en && en_p) begin
                chk(en_hi == ENC, "R6", en_hi, ENC);
                gap = 0;
                counting = 1'b1;
            end
            if (in_ready && (!ser_clk || ser_data || lcd_en)) idle_bad++;
            en_p  = lcd_en;
            clk_p = ser_clk;
            rdy_p = in_ready;
            dat_p = ser_data;
        end
    end

    // Offer a byte and hold it until accepted; valid stays high afterwards.
    task automatic send(input logic rs, input logic [7:0] d, input logic m4);
        @(negedge clk);
        in_valid = 1'b1; in_rs = rs; in_data = d; in_bus4 = m4;
        while (!in_ready) @(negedge clk);
        if (m4) begin push(rs, {4'h0, d[7:4]}, 4); push(rs, {4'h0, d[3:0]}, 4); end
        else push(rs, d, 8);
        @(negedge clk);
        chk(!in_ready, "R2,R11", in_ready, 0);
        chk(lcd_rs == rs, "R8", lcd_rs, rs);
    endtask

    // Drop valid and scramble every input while busy (R9).
    task automatic wait_idle();
        while (!in_ready) begin
            in_valid = 1'b0;
            in_data  = 8'($urandom);
            in_rs    = 1'($urandom);
            in_bus4  = 1'($urandom);
            @(negedge clk);
        end
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(in_ready && ser_clk && !ser_data && !lcd_en && !lcd_rs, "R1",
            {in_ready, ser_clk, ser_data, lcd_en, lcd_rs}, 5'b11000);

        send(1'b0, 8'hA5, 1'b0); wait_idle();
        send(1'b1, 8'h3C, 1'b1); wait_idle();
        send(1'b0, 8'h00, 1'b1); wait_idle();
        send(1'b1, 8'hFF, 1'b0); wait_idle();
        // R11: back-to-back in both modes with valid held high
        send(1'b0, 8'h81, 1'b1);
        send(1'b1, 8'h7E, 1'b0);
        send(1'b0, 8'hC3, 1'b1);
        wait_idle();
        for (int i = 0; i < 24; i++) begin
            send(1'($urandom), 8'($urandom), 1'($urandom));
            if (($urandom % 3) != 0) wait_idle();
        end
        wait_idle();
        repeat (SETL + 5) @(negedge clk);

        chk(rd_ptr == wr_ptr, "R3,R4 strobe count", rd_ptr, wr_ptr);
        chk(idle_bad == 0, "R10", idle_bad, 0);
        chk(r5_bad == 0, "R5", r5_bad, 0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule